// File: doc/BRIEF.md
# Write-Back Data Cache Controller

This block is a direct-mapped data cache that sits between a processor load/store port and a word-wide memory master able to issue single or burst transfers. Each line keeps one tag, one dirty flag and one valid flag per word, so a line can hold some words while others are still absent. Loads that find their word present return data in the following cycle. Every other cacheable access stalls the processor while the controller writes back, fetches, or both, and the access then completes from the cache.

Stores always land in the cache. A full-word store that misses claims the line without reading memory and marks only that word present. A narrower store that misses first reads the one word it targets, then merges its bytes. When a line has to be replaced and holds modified data, it is written out first. One present word is written with a single-beat transfer. Several present words are written with a burst over the whole line, and a per-beat byte strobe masks out the words that are absent. Requests flagged non-cacheable never touch the cache and are forwarded unchanged to a separate bypass port.

Byte addresses split, from the least significant bit, into a byte offset, a word select, a line index and a tag. With the default settings these are 2, 2, 3 and 9 bits of a 16-bit address.

Top module: `wb_dcache`

## Requirements
- R1: A cacheable load whose tag matches and whose addressed word is present completes without stall and without any memory command, and `cpu_rvalid` with the data is high in the following cycle.
- R2: A cacheable load that misses, with the victim clean or empty, issues exactly one read command with `mem_cmd_len` = words per line − 1 (length is beats − 1) at the line's base address. It stalls for at least one cycle per word of the line, then returns the fetched data.
- R3: A matching tag alone is not a hit. A load to a word not yet present refills the line with a burst, and the refill leaves words already present unchanged.
- R4: A full-word store (`cpu_be` all ones) that misses on a clean or empty line completes without stall and without any memory read. Only that word becomes present.
- R5: A store with `cpu_be` not all ones that misses issues a single-word read (`mem_cmd_len` = 0) at the addressed word, and a later load returns the fetched word with the store's bytes merged in.
- R6: Every cacheable store updates the cached data, and memory keeps its old value until the line is evicted.
- R7: A dirty victim is written to memory before the line is refilled. If it has exactly one present word, the write is one beat (`mem_cmd_len` = 0) at that word's address.
- R8: A dirty victim with more than one present word is written as a burst of the whole line from its base (`mem_cmd_len` = words − 1). The strobe is all ones on present words and all zeros on absent ones.
- R9: A write-back leaves the line clean. A line refilled under a new tag and never stored to causes no write command when it is evicted.
- R10: Non-cacheable accesses go to the bypass port and stall until `byp_ack`. They issue no memory command and leave cached contents unchanged.
- R11: After reset every line is empty and clean, and no memory command or read response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, held until accepted |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_cacheable | input | 1 | Address lies in the cacheable range |
| cpu_be | input | 4 | Byte enables of a store |
| cpu_addr | input | 16 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data |
| cpu_rvalid | output | 1 | Load data valid, one cycle after acceptance |
| cpu_stall | output | 1 | Request not accepted this cycle |
| mem_cmd_valid | output | 1 | Memory command valid |
| mem_cmd_ready | input | 1 | Memory command accepted |
| mem_cmd_we | output | 1 | 1 = write command |
| mem_cmd_addr | output | 16 | Byte address of the first beat |
| mem_cmd_len | output | 2 | Beats minus one |
| mem_wvalid | output | 1 | Write beat valid |
| mem_wready | input | 1 | Write beat accepted |
| mem_wdata | output | 32 | Write beat data |
| mem_wstrb | output | 4 | Write beat byte strobe |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | 32 | Read beat data |
| byp_req | output | 1 | Bypass request |
| byp_we | output | 1 | Bypass store |
| byp_be | output | 4 | Bypass byte enables |
| byp_addr | output | 16 | Bypass address |
| byp_wdata | output | 32 | Bypass store data |
| byp_ack | input | 1 | Bypass access complete |
| byp_rdata | input | 32 | Bypass load data |

## Verification
A wrong valid bit shows up at once as a memory command where none is expected, or as a missing one. It can also show as a load that returns stale memory contents in the cycle after acceptance. A wrong dirty flag only shows up at eviction, possibly much later. It appears as a write command that should not be there, a missing one, or a burst that should have been a single beat. The bench therefore evicts lines deliberately and inspects the modelled memory after each write-back. That inspection includes the words the strobe had to protect.

// File: rtl/dc_pkg.sv
package dc_pkg;

    localparam int unsigned ADDR_W     = 16;
    localparam int unsigned DATA_W     = 32;
    localparam int unsigned LINE_WORDS = 4;
    localparam int unsigned LINE_CNT   = 8;

    localparam int unsigned BE_W   = DATA_W / 8;
    localparam int unsigned OFF_W  = $clog2(BE_W);
    localparam int unsigned WSEL_W = $clog2(LINE_WORDS);
    localparam int unsigned IDX_W  = $clog2(LINE_CNT);
    localparam int unsigned TAG_W  = ADDR_W - IDX_W - WSEL_W - OFF_W;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [WSEL_W-1:0] wsel_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [BE_W-1:0]   be_t;
    typedef logic [LINE_WORDS-1:0][DATA_W-1:0] line_t;

    typedef struct packed {
        tag_t                  tag;
        logic [LINE_WORDS-1:0] valid;
        logic                  dirty;
    } meta_t;

    localparam int unsigned META_W = $bits(meta_t);

    typedef struct packed {
        logic  en;
        wsel_t wsel;
        be_t   be;
        word_t data;
    } wword_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_WB_CMD, ST_WB_DAT, ST_RD_CMD, ST_RD_DAT
    } st_t;

    function automatic word_t merge_bytes(input word_t old_w, input word_t new_w, input be_t be);
        word_t r;
        r = old_w;
        for (int b = 0; b < int'(BE_W); b++)
            if (be[b]) r[b*8 +: 8] = new_w[b*8 +: 8];
        return r;
    endfunction

    function automatic wsel_t lowest_set(input logic [LINE_WORDS-1:0] v);
        wsel_t r;
        r = '0;
        for (int i = int'(LINE_WORDS) - 1; i >= 0; i--)
            if (v[i]) r = wsel_t'(i);
        return r;
    endfunction

    function automatic logic [LINE_WORDS-1:0] word_bit(input wsel_t w);
        return LINE_WORDS'(1) << w;
    endfunction

endpackage

// File: rtl/dc_store.sv
module dc_store
    import dc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  idx_t   idx,
    output meta_t  rd_meta,
    output line_t  rd_line,
    input  logic   meta_we,
    input  meta_t  meta_wr,
    input  wword_t wr
);

    logic [LINE_CNT-1:0][META_W-1:0] meta_flat;
    logic [LINE_CNT-1:0][LINE_WORDS-1:0][DATA_W-1:0] data_flat;

    for (genvar l = 0; l < int'(LINE_CNT); l++) begin : g_line
        meta_t m_q;
        always_ff @(posedge clk) begin
            if (rst)
                m_q <= '0;
            else if (meta_we && idx == idx_t'(l))
                m_q <= meta_wr;
        end
        assign meta_flat[l] = m_q;

        for (genvar w = 0; w < int'(LINE_WORDS); w++) begin : g_word
            word_t d_q;
            always_ff @(posedge clk) begin
                if (wr.en && idx == idx_t'(l) && wr.wsel == wsel_t'(w))
                    d_q <= merge_bytes(d_q, wr.data, wr.be);
            end
            assign data_flat[l][w] = d_q;
        end
    end

    assign rd_meta = meta_t'(meta_flat[idx]);
    assign rd_line = data_flat[idx];

    // a line holding no words must never be flagged as modified
    assert_empty_clean_R9: assert property (@(posedge clk) disable iff (rst)
        !(|rd_meta.valid) |-> !rd_meta.dirty);

endmodule

// File: rtl/dc_fsm.sv
module dc_fsm
    import dc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_act,
    input  logic        we,
    input  be_t         be,
    input  tag_t        rq_tag,
    input  idx_t        rq_idx,
    input  wsel_t       rq_wsel,
    input  word_t       wdata,
    input  meta_t       meta,
    input  line_t       line,
    output logic        done,
    output logic        meta_we,
    output meta_t       meta_wr,
    output wword_t      wr,
    output logic        mem_cmd_valid,
    input  logic        mem_cmd_ready,
    output logic        mem_cmd_we,
    output logic [ADDR_W-1:0] mem_cmd_addr,
    output wsel_t       mem_cmd_len,
    output logic        mem_wvalid,
    input  logic        mem_wready,
    output word_t       mem_wdata,
    output be_t         mem_wstrb,
    input  logic        mem_rvalid,
    input  word_t       mem_rdata
);

    localparam wsel_t LAST_BEAT = wsel_t'(LINE_WORDS - 1);

    st_t   state, nxt;
    wsel_t beat, nxt_beat, wb_word, nxt_ww;
    logic  rd_single, nxt_rs, wb_single, nxt_ws;

    logic  tag_hit, word_hit, full;
    wsel_t pos;

    assign tag_hit  = (meta.tag == rq_tag) && (|meta.valid);
    assign word_hit = tag_hit && meta.valid[rq_wsel];
    assign full     = &be;

    always_comb begin
        nxt = state; nxt_beat = beat; nxt_ww = wb_word;
        nxt_rs = rd_single; nxt_ws = wb_single;
        done = 1'b0; meta_we = 1'b0; meta_wr = meta; wr = '0;
        mem_cmd_valid = 1'b0; mem_cmd_we = 1'b0; mem_cmd_addr = '0; mem_cmd_len = '0;
        mem_wvalid = 1'b0; mem_wdata = '0; mem_wstrb = '0;
        if (state == ST_WB_DAT) pos = wb_single ? wb_word : beat;
        else                    pos = rd_single ? rq_wsel : beat;

        case (state)
            ST_IDLE: if (req_act) begin
                if (!we && word_hit) begin
                    done = 1'b1;
                end else if (we && (word_hit || (tag_hit && full))) begin
                    done = 1'b1;
                    wr.en = 1'b1; wr.wsel = rq_wsel; wr.be = be; wr.data = wdata;
                    meta_we = 1'b1;
                    meta_wr.valid = meta.valid | word_bit(rq_wsel);
                    meta_wr.dirty = 1'b1;
                end else if (!tag_hit && meta.dirty) begin
                    nxt = ST_WB_CMD;
                    nxt_ws = ($countones(meta.valid) == 1);
                    nxt_ww = lowest_set(meta.valid);
                end else if (we && !tag_hit && full) begin
                    done = 1'b1;
                    wr.en = 1'b1; wr.wsel = rq_wsel; wr.be = be; wr.data = wdata;
                    meta_we = 1'b1;
                    meta_wr.tag = rq_tag;
                    meta_wr.valid = word_bit(rq_wsel);
                    meta_wr.dirty = 1'b1;
                end else begin
                    nxt = ST_RD_CMD;
                    nxt_rs = we;
                    if (!tag_hit) begin
                        meta_we = 1'b1;
                        meta_wr.tag = rq_tag;
                        meta_wr.valid = '0;
                        meta_wr.dirty = 1'b0;
                    end
                end
            end
            ST_WB_CMD: begin
                mem_cmd_valid = 1'b1;
                mem_cmd_we    = 1'b1;
                mem_cmd_addr  = {meta.tag, rq_idx, (wb_single ? wb_word : wsel_t'(0)), {OFF_W{1'b0}}};
                mem_cmd_len   = wb_single ? wsel_t'(0) : LAST_BEAT;
                if (mem_cmd_ready) begin nxt = ST_WB_DAT; nxt_beat = '0; end
            end
            ST_WB_DAT: begin
                mem_wvalid = 1'b1;
                mem_wdata  = line[pos];
                mem_wstrb  = meta.valid[pos] ? '1 : '0;
                if (mem_wready) begin
                    nxt_beat = beat + 1'b1;
                    if (wb_single || beat == LAST_BEAT) begin
                        nxt = ST_IDLE;
                        meta_we = 1'b1;
                        meta_wr.valid = '0;
                        meta_wr.dirty = 1'b0;
                    end
                end
            end
            ST_RD_CMD: begin
                mem_cmd_valid = 1'b1;
                mem_cmd_addr  = {rq_tag, rq_idx, (rd_single ? rq_wsel : wsel_t'(0)), {OFF_W{1'b0}}};
                mem_cmd_len   = rd_single ? wsel_t'(0) : LAST_BEAT;
                if (mem_cmd_ready) begin nxt = ST_RD_DAT; nxt_beat = '0; end
            end
            ST_RD_DAT: if (mem_rvalid) begin
                nxt_beat = beat + 1'b1;
                if (!meta.valid[pos]) begin
                    wr.en = 1'b1; wr.wsel = pos; wr.be = '1; wr.data = mem_rdata;
                    meta_we = 1'b1;
                    meta_wr.valid = meta.valid | word_bit(pos);
                end
                if (rd_single || beat == LAST_BEAT) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE; beat <= '0; wb_word <= '0;
            rd_single <= 1'b0; wb_single <= 1'b0;
        end else begin
            state <= nxt; beat <= nxt_beat; wb_word <= nxt_ww;
            rd_single <= nxt_rs; wb_single <= nxt_ws;
        end
    end

    // write commands are either one word or a whole line
    assert_wb_len_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_cmd_valid && mem_cmd_we) |-> (mem_cmd_len == '0 || mem_cmd_len == LAST_BEAT));

    // a command waiting for acceptance keeps its address
    assert_cmd_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_cmd_valid && !mem_cmd_ready) |=> (mem_cmd_valid && $stable(mem_cmd_addr)));

    // a single-beat victim write carries a present word
    assert_single_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        (mem_wvalid && wb_single) |-> (&mem_wstrb));

endmodule

// File: rtl/wb_dcache.sv
module wb_dcache
    import dc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              cpu_cacheable,
    input  logic [BE_W-1:0]   cpu_be,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_rvalid,
    output logic              cpu_stall,
    output logic              mem_cmd_valid,
    input  logic              mem_cmd_ready,
    output logic              mem_cmd_we,
    output logic [ADDR_W-1:0] mem_cmd_addr,
    output logic [WSEL_W-1:0] mem_cmd_len,
    output logic              mem_wvalid,
    input  logic              mem_wready,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [BE_W-1:0]   mem_wstrb,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              byp_req,
    output logic              byp_we,
    output logic [BE_W-1:0]   byp_be,
    output logic [ADDR_W-1:0] byp_addr,
    output logic [DATA_W-1:0] byp_wdata,
    input  logic              byp_ack,
    input  logic [DATA_W-1:0] byp_rdata
);

    tag_t   rq_tag;
    idx_t   rq_idx;
    wsel_t  rq_wsel;
    meta_t  meta, meta_wr;
    line_t  line;
    wword_t wr;
    logic   meta_we, done, req_act;

    assign rq_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
    assign rq_idx  = cpu_addr[OFF_W+WSEL_W +: IDX_W];
    assign rq_wsel = cpu_addr[OFF_W +: WSEL_W];
    assign req_act = cpu_req && cpu_cacheable;

    dc_store u_store (
        .clk(clk), .rst(rst), .idx(rq_idx),
        .rd_meta(meta), .rd_line(line),
        .meta_we(meta_we), .meta_wr(meta_wr), .wr(wr)
    );

    dc_fsm u_fsm (
        .clk(clk), .rst(rst), .req_act(req_act), .we(cpu_we), .be(cpu_be),
        .rq_tag(rq_tag), .rq_idx(rq_idx), .rq_wsel(rq_wsel), .wdata(cpu_wdata),
        .meta(meta), .line(line), .done(done),
        .meta_we(meta_we), .meta_wr(meta_wr), .wr(wr),
        .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready),
        .mem_cmd_we(mem_cmd_we), .mem_cmd_addr(mem_cmd_addr), .mem_cmd_len(mem_cmd_len),
        .mem_wvalid(mem_wvalid), .mem_wready(mem_wready),
        .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    assign byp_req   = cpu_req && !cpu_cacheable;
    assign byp_we    = cpu_we;
    assign byp_be    = cpu_be;
    assign byp_addr  = cpu_addr;
    assign byp_wdata = cpu_wdata;

    assign cpu_stall = cpu_req && (cpu_cacheable ? !done : !byp_ack);

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_rvalid <= 1'b0;
            cpu_rdata  <= '0;
        end else begin
            cpu_rvalid <= 1'b0;
            if (done && !cpu_we) begin
                cpu_rvalid <= 1'b1;
                cpu_rdata  <= line[rq_wsel];
            end else if (byp_req && byp_ack && !cpu_we) begin
                cpu_rvalid <= 1'b1;
                cpu_rdata  <= byp_rdata;
            end
        end
    end

    // an accepted cacheable load answers in the next cycle
    assert_hit_rvalid_R1: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_cacheable && !cpu_we && !cpu_stall) |=> cpu_rvalid);

    // bypass traffic never reaches the memory master
    assert_bypass_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !cpu_cacheable) |-> !mem_cmd_valid);

    // nothing is pending right after reset
    assert_reset_idle_R11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!mem_cmd_valid && !cpu_rvalid && !mem_wvalid));

endmodule

// File: tb/sim_wb_dcache.sv
module sim_wb_dcache;
    import dc_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cpu_req = 1'b0, cpu_we = 1'b0, cpu_cacheable = 1'b0;
    logic [BE_W-1:0]   cpu_be = '0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic [DATA_W-1:0] cpu_rdata;
    logic              cpu_rvalid, cpu_stall;
    logic              mem_cmd_valid, mem_cmd_we;
    logic              mem_cmd_ready = 1'b1;
    logic [ADDR_W-1:0] mem_cmd_addr;
    logic [WSEL_W-1:0] mem_cmd_len;
    logic              mem_wvalid;
    logic              mem_wready = 1'b1;
    logic [DATA_W-1:0] mem_wdata;
    logic [BE_W-1:0]   mem_wstrb;
    logic              mem_rvalid = 1'b0;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic              byp_req, byp_we;
    logic [BE_W-1:0]   byp_be;
    logic [ADDR_W-1:0] byp_addr;
    logic [DATA_W-1:0] byp_wdata;
    logic              byp_ack = 1'b0;
    logic [DATA_W-1:0] byp_rdata = '0;

    logic [31:0] mem  [0:1023];
    logic [31:0] gold [0:1023];
    logic [31:0] exp_q [$];
    string       tag_q [$];

    int n_chk = 0, n_fail = 0;
    int n_rd = 0, n_wr = 0, n_byw = 0;
    logic [15:0] last_rd_addr = '0, last_wr_addr = '0;
    int last_rd_len = 0, last_wr_len = 0;
    logic [31:0] byp_last_wd = '0;
    logic [3:0]  byp_last_be = '0;
    bit finished = 1'b0;

    wb_dcache u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] byp_val(input logic [15:0] a);
        return 32'hB000_0000 | {16'h0, a};
    endfunction

    function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
        logic [31:0] r;
        r = o;
        for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = n[b*8 +: 8];
        return r;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic access(input bit we, input logic [3:0] be, input logic [15:0] a,
                          input logic [31:0] wd, input bit cach, input string rq,
                          output int stalls);
        stalls = 0;
        if (!we) begin
            exp_q.push_back(cach ? gold[a[11:2]] : byp_val(a));
            tag_q.push_back(rq);
        end else if (cach) begin
            gold[a[11:2]] = mrg(gold[a[11:2]], wd, be);
        end
        cpu_req = 1'b1; cpu_we = we; cpu_be = be; cpu_addr = a;
        cpu_wdata = wd; cpu_cacheable = cach;
        #1;
        while (cpu_stall) begin
            stalls++;
            @(negedge clk); #1;
        end
        @(posedge clk);
        @(negedge clk);
        cpu_req = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin
            mem[i]  = 32'hA000_0000 + i;
            gold[i] = 32'hA000_0000 + i;
        end
    end

    // memory responder: commands always accepted, read beats back to back
    initial begin
        int          rd_pend;
        logic [9:0]  rd_ptr, wr_ptr;
        rd_pend = 0; rd_ptr = '0; wr_ptr = '0;
        forever begin
            @(negedge clk); #2;
            mem_rvalid = 1'b0;
            if (rd_pend > 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = mem[rd_ptr];
                rd_ptr++;
                rd_pend--;
            end
            if (mem_cmd_valid) begin
                if (mem_cmd_we) begin
                    n_wr++; last_wr_len = int'(mem_cmd_len); last_wr_addr = mem_cmd_addr;
                    wr_ptr = mem_cmd_addr[11:2];
                end else begin
                    n_rd++; last_rd_len = int'(mem_cmd_len); last_rd_addr = mem_cmd_addr;
                    rd_ptr = mem_cmd_addr[11:2];
                    rd_pend = int'(mem_cmd_len) + 1;
                end
            end
            if (mem_wvalid) begin
                mem[wr_ptr] = mrg(mem[wr_ptr], mem_wdata, mem_wstrb);
                wr_ptr++;
            end
        end
    end

    // bypass responder: one-cycle acknowledge
    initial begin
        forever begin
            @(negedge clk); #2;
            if (byp_ack) byp_ack = 1'b0;
            else if (byp_req) begin
                byp_ack = 1'b1;
                byp_rdata = byp_val(byp_addr);
                if (byp_we) begin
                    n_byw++; byp_last_wd = byp_wdata; byp_last_be = byp_be;
                end
            end
        end
    end

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk); #3;
            if (cpu_rvalid) begin
                if (exp_q.size() == 0) chk(1'b0, "R1", "unexpected load data", cpu_rdata, 32'h0);
                else begin
                    logic [31:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(cpu_rdata == e, t, "load data", cpu_rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL R2 watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int s, n0, w0;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(!mem_cmd_valid, "R11", "cmd valid in reset", 32'(mem_cmd_valid), 0);
        chk(!cpu_stall, "R11", "stall in reset", 32'(cpu_stall), 0);
        chk(!cpu_rvalid, "R11", "rvalid in reset", 32'(cpu_rvalid), 0);
        rst = 1'b0;
        @(negedge clk);

        // R2: load miss on an empty line
        n0 = n_rd;
        access(1'b0, 4'hF, 16'h0014, 0, 1'b1, "R2", s);
        chk(n_rd == n0 + 1, "R2", "read commands", n_rd, n0 + 1);
        chk(last_rd_len == 3, "R2", "read length", last_rd_len, 3);
        chk(last_rd_addr == 16'h0010, "R2", "read address", 32'(last_rd_addr), 32'h10);
        chk(s >= 4, "R2", "stall cycles", s, 4);

        // R1: hit on another word of the filled line
        access(1'b0, 4'hF, 16'h0018, 0, 1'b1, "R1", s);
        chk(n_rd == n0 + 1, "R1", "read commands on hit", n_rd, n0 + 1);
        chk(s == 0, "R1", "stall on hit", s, 0);

        // R6: store hit updates cache, memory unchanged
        access(1'b1, 4'hF, 16'h001C, 32'h1111_2222, 1'b1, "R6", s);
        chk(s == 0, "R6", "stall on store hit", s, 0);
        chk(n_wr == 0, "R6", "write commands", n_wr, 0);
        chk(mem[7] == 32'hA000_0007, "R6", "memory before eviction", mem[7], 32'hA000_0007);
        access(1'b0, 4'hF, 16'h001C, 0, 1'b1, "R6", s);

        // R5: partial store miss fetches one word
        n0 = n_rd;
        access(1'b1, 4'b0001, 16'h0024, 32'h0000_00C5, 1'b1, "R5", s);
        chk(n_rd == n0 + 1, "R5", "read commands", n_rd, n0 + 1);
        chk(last_rd_len == 0, "R5", "read length", last_rd_len, 0);
        chk(last_rd_addr == 16'h0024, "R5", "read address", 32'(last_rd_addr), 32'h24);
        access(1'b0, 4'hF, 16'h0024, 0, 1'b1, "R5", s);

        // R4: full-word store miss allocates without reading
        n0 = n_rd;
        access(1'b1, 4'hF, 16'h0034, 32'h3333_4444, 1'b1, "R4", s);
        chk(s == 0, "R4", "stall on allocate", s, 0);
        chk(n_rd == n0, "R4", "read commands", n_rd, n0);
        access(1'b0, 4'hF, 16'h0034, 0, 1'b1, "R4", s);
        chk(n_rd == n0, "R4", "read commands on load", n_rd, n0);

        // R3: matching tag but absent word is a miss; refill keeps present word
        access(1'b0, 4'hF, 16'h0038, 0, 1'b1, "R3", s);
        chk(n_rd == n0 + 1, "R3", "read commands", n_rd, n0 + 1);
        chk(last_rd_len == 3, "R3", "read length", last_rd_len, 3);
        access(1'b0, 4'hF, 16'h0034, 0, 1'b1, "R3", s);

        // R7: dirty victim with one present word
        w0 = n_wr;
        access(1'b0, 4'hF, 16'h00A4, 0, 1'b1, "R7", s);
        chk(n_wr == w0 + 1, "R7", "write commands", n_wr, w0 + 1);
        chk(last_wr_len == 0, "R7", "write length", last_wr_len, 0);
        chk(last_wr_addr == 16'h0024, "R7", "write address", 32'(last_wr_addr), 32'h24);
        chk(mem[9] == 32'hA000_00C5, "R7", "written word", mem[9], 32'hA000_00C5);

        // R8: dirty victim with two of four words present
        access(1'b1, 4'hF, 16'h0040, 32'h5555_0000, 1'b1, "R8", s);
        access(1'b1, 4'hF, 16'h0048, 32'h5555_0002, 1'b1, "R8", s);
        access(1'b0, 4'hF, 16'h00C0, 0, 1'b1, "R8", s);
        chk(last_wr_len == 3, "R8", "write length", last_wr_len, 3);
        chk(last_wr_addr == 16'h0040, "R8", "write address", 32'(last_wr_addr), 32'h40);
        chk(mem[16] == 32'h5555_0000, "R8", "word 0", mem[16], 32'h5555_0000);
        chk(mem[18] == 32'h5555_0002, "R8", "word 2", mem[18], 32'h5555_0002);
        chk(mem[17] == 32'hA000_0011, "R8", "masked word 1", mem[17], 32'hA000_0011);
        chk(mem[19] == 32'hA000_0013, "R8", "masked word 3", mem[19], 32'hA000_0013);
        access(1'b0, 4'hF, 16'h00B0, 0, 1'b1, "R8", s);
        chk(last_wr_len == 3, "R8", "full line length", last_wr_len, 3);
        chk(last_wr_addr == 16'h0030, "R8", "full line address", 32'(last_wr_addr), 32'h30);
        chk(mem[13] == 32'h3333_4444, "R8", "full line word", mem[13], 32'h3333_4444);

        // R9: clean line refilled under new tag evicts without a write
        w0 = n_wr; n0 = n_rd;
        access(1'b0, 4'hF, 16'h0024, 0, 1'b1, "R9", s);
        chk(n_wr == w0, "R9", "write commands", n_wr, w0);
        chk(n_rd == n0 + 1, "R9", "read commands", n_rd, n0 + 1);

        // R10: bypass accesses
        w0 = n_wr; n0 = n_rd;
        access(1'b0, 4'hF, 16'h0014, 0, 1'b0, "R10", s);
        chk(s >= 1, "R10", "bypass stall", s, 1);
        access(1'b1, 4'b0011, 16'h0018, 32'hDEAD_BEEF, 1'b0, "R10", s);
        chk(byp_last_wd == 32'hDEAD_BEEF, "R10", "bypass data", byp_last_wd, 32'hDEAD_BEEF);
        chk(byp_last_be == 4'b0011, "R10", "bypass enables", 32'(byp_last_be), 32'h3);
        chk(n_rd == n0 && n_wr == w0, "R10", "memory commands", n_rd + n_wr, n0 + w0);
        access(1'b0, 4'hF, 16'h0018, 0, 1'b1, "R10", s);
        chk(n_rd == n0, "R10", "cached line kept", n_rd, n0);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R1", "loads left unanswered", exp_q.size(), 0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule